// File: doc/BRIEF.md
# External Interrupt Pin Sampler

This block turns one asynchronous external interrupt pin into a request for the interrupt controller. The pin first passes through a synchroniser. After that it is looked at only when the machine-cycle strobe is high. A mode input selects one of two trigger types. In low-level mode the request simply mirrors the most recent sample. In falling-edge mode a high sample followed by a low sample latches a flag. The flag stays set until the controller acknowledges the vector or software clears it.

The synchroniser carries a fill indicator beside the data. Strobes are ignored until the synchronised value reflects the real pin. The first accepted sample only primes the edge detector, so a pin that is already low when reset ends produces no request.

Top module: `extirq_sampler`

## Requirements
- R1: While reset is asserted and right after it, `irq_req_o` and `flag_o` are 0.
- R2: A pin change reaches the sample register through two synchroniser flops and is captured only on a clock edge where `mc_stb_i` is 1. When the pin is driven before clock edge k and the strobe is held high, `irq_req_o` in level mode changes after edge k+2, not earlier. Without a strobe the outputs do not change.
- R3: With `edge_mode_i` = 0 (low-level trigger), `irq_req_o` is 1 exactly while the latest accepted sample is 0. It returns to 0 once a high sample is taken. `flag_o` is not set in this mode.
- R4: With `edge_mode_i` = 1 (falling-edge trigger), a strobe whose sample is 0 while the previous accepted sample was 1 sets `flag_o` on that clock edge.
- R5: A set flag stays set while neither `vec_ack_i` nor `sw_clr_i` is high, whatever the pin does.
- R6: A one-cycle `vec_ack_i` clears `flag_o` on that clock edge.
- R7: A one-cycle `sw_clr_i` clears `flag_o` on that clock edge.
- R8: When a flag set and a clear (`vec_ack_i` or `sw_clr_i`) fall on the same edge, the flag ends up set.
- R9: A pin held low through reset and afterwards produces no flag, because the first accepted sample after reset only primes the detector.
- R10: A pin pulse that starts and ends between two strobes is not seen in either mode.
- R11: In edge mode `irq_req_o` equals `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| mc_stb_i | input | 1 | Machine-cycle strobe, one clock wide per sample |
| edge_mode_i | input | 1 | 0 = low-level trigger, 1 = falling-edge trigger |
| vec_ack_i | input | 1 | Controller has vectored to this source's handler |
| sw_clr_i | input | 1 | Software clear of the latched flag |
| irq_req_o | output | 1 | Request to the interrupt controller |
| flag_o | output | 1 | Latched edge flag, readable by software |

## Verification
The assertions assume the following about the inputs:
- `edge_mode_i` does not change while a judgement about a level-mode rise is made.
- The acknowledge and software-clear inputs are single-cycle synchronous pulses. The clear checks are only applied on cycles without a strobe, so they do not collide with a set.
- The pin itself may change at any cycle.

The stimulus meets these assumptions. It changes inputs only between clock edges, keeps the mode stable for long stretches, and issues clears and acknowledges as one-cycle pulses. The directed sequences use strobe patterns chosen so that short pulses fall between samples and so that a set and a clear meet on one exact edge.

// File: rtl/extirq_pkg.sv
`timescale 1ns/1ps
package extirq_pkg;
    typedef enum logic {
        TRIG_LOW_LEVEL = 1'b0,
        TRIG_FALLING   = 1'b1
    } trig_e;

    typedef struct packed {
        logic smp;
        logic primed;
    } smp_st_t;

    typedef struct packed {
        logic flag;
    } flag_st_t;
endpackage

// File: rtl/extirq_sync.sv
`timescale 1ns/1ps
module extirq_sync #(
    parameter int unsigned DEPTH = 2,
    parameter logic        IDLE  = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o,
    output logic vld_o
);
    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic [DEPTH-1:0] data;
        logic [DEPTH-1:0] fill;
    } chain_t;

    chain_t c_d, c_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                c_d      = c_q;
                c_d.data = d_i;
                c_d.fill = 1'b1;
            end
        end else begin : g_multi
            always_comb begin
                c_d      = c_q;
                c_d.data = {c_q.data[DEPTH-2:0], d_i};
                c_d.fill = {c_q.fill[DEPTH-2:0], 1'b1};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q.data <= {DEPTH{IDLE}};
            c_q.fill <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign q_o   = c_q.data[LAST];
    assign vld_o = c_q.fill[LAST];
endmodule

// File: rtl/extirq_sample.sv
`timescale 1ns/1ps
module extirq_sample
    import extirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stb_i,
    input  logic sync_i,
    input  logic vld_i,
    output logic smp_o,
    output logic primed_o,
    output logic fall_o
);
    smp_st_t s_d, s_q;
    logic    take;

    always_comb begin
        take   = stb_i & vld_i;
        s_d    = s_q;
        fall_o = 1'b0;
        if (take) begin
            fall_o     = s_q.primed & s_q.smp & ~sync_i;
            s_d.smp    = sync_i;
            s_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.smp    <= 1'b1;
            s_q.primed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign smp_o    = s_q.smp;
    assign primed_o = s_q.primed;
endmodule

// File: rtl/extirq_flag.sv
`timescale 1ns/1ps
module extirq_flag
    import extirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_st_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (set_i) begin
            f_d.flag = 1'b1;
        end else if (clr_i) begin
            f_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q.flag <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag_o = f_q.flag;
endmodule

// File: rtl/extirq_sampler.sv
`timescale 1ns/1ps
module extirq_sampler
    import extirq_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic mc_stb_i,
    input  logic edge_mode_i,
    input  logic vec_ack_i,
    input  logic sw_clr_i,
    output logic irq_req_o,
    output logic flag_o
);
    trig_e mode_w;
    logic  sync_w, sync_vld_w;
    logic  smp_w, primed_w, fall_w;
    logic  set_w, clr_w;

    assign mode_w = trig_e'(edge_mode_i);

    extirq_sync #(
        .DEPTH (SYNC_DEPTH),
        .IDLE  (1'b1)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (sync_w),
        .vld_o  (sync_vld_w)
    );

    extirq_sample u_sample (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stb_i    (mc_stb_i),
        .sync_i   (sync_w),
        .vld_i    (sync_vld_w),
        .smp_o    (smp_w),
        .primed_o (primed_w),
        .fall_o   (fall_w)
    );

    always_comb begin
        set_w = (mode_w == TRIG_FALLING) & fall_w;
        clr_w = vec_ack_i | sw_clr_i;
    end

    extirq_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .flag_o (flag_o)
    );

    always_comb begin
        if (mode_w == TRIG_FALLING) begin
            irq_req_o = flag_o;
        end else begin
            irq_req_o = primed_w & ~smp_w;
        end
    end
endmodule

// File: rtl/extirq_sampler_chk.sv
`timescale 1ns/1ps
module extirq_sampler_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic mc_stb_i,
    input logic edge_mode_i,
    input logic vec_ack_i,
    input logic sw_clr_i,
    input logic irq_req_o,
    input logic flag_o,
    input logic sync_i,
    input logic vld_i,
    input logic smp_i,
    input logic primed_i
);
    assert_quiet_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mc_stb_i && vld_i) |=> ($stable(smp_i) && $stable(primed_i)));

    assert_level_rise_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!edge_mode_i && $past(!edge_mode_i) && $rose(irq_req_o)) |-> $past(mc_stb_i));

    assert_edge_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mc_stb_i && vld_i && primed_i && smp_i && !sync_i && edge_mode_i) |=> flag_o);

    assert_flag_origin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> $past(mc_stb_i && edge_mode_i));

    assert_flag_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !vec_ack_i && !sw_clr_i) |=> flag_o);

    assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_ack_i && !mc_stb_i) |=> !flag_o);

    assert_swclr_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_clr_i && !mc_stb_i) |=> !flag_o);

    assert_unprimed_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !primed_i |-> !flag_o);
endmodule

bind extirq_sampler extirq_sampler_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mc_stb_i    (mc_stb_i),
    .edge_mode_i (edge_mode_i),
    .vec_ack_i   (vec_ack_i),
    .sw_clr_i    (sw_clr_i),
    .irq_req_o   (irq_req_o),
    .flag_o      (flag_o),
    .sync_i      (sync_w),
    .vld_i       (sync_vld_w),
    .smp_i       (smp_w),
    .primed_i    (primed_w)
);

// File: tb/test_extirq_sampler.sv
`timescale 1ns/1ps
module test_extirq_sampler;
    localparam real CLK_NS = 5.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0, stb = 1'b0, mode = 1'b1, ack = 1'b0, clr = 1'b0;
    logic irq, flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    extirq_sampler i_extirq_sampler (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pin),
        .mc_stb_i    (stb),
        .edge_mode_i (mode),
        .vec_ack_i   (ack),
        .sw_clr_i    (clr),
        .irq_req_o   (irq),
        .flag_o      (flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: a queue stands in for the synchroniser delay
    bit pipe[$];
    int warm;
    bit m_smp, m_primed, m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe = '{1'b1, 1'b1};
            warm = 0;
            m_smp = 1'b1;
            m_primed = 1'b0;
            m_flag = 1'b0;
        end else begin
            bit seen, ready, fell;
            seen = pipe.pop_front();
            pipe.push_back(pin);
            ready = (warm >= 2);
            if (warm < 2) warm++;
            fell = 1'b0;
            if (stb && ready) begin
                fell = m_primed && m_smp && !seen;
                m_smp = seen;
                m_primed = 1'b1;
            end
            if (mode && fell) m_flag = 1'b1;
            else if (ack || clr) m_flag = 1'b0;
        end
    end

    always @(posedge clk) begin
        #1;
        if (model_on && rst_n) begin
            chk("R4 flag vs model", flag, m_flag);
            chk("R11/R3 request vs model", irq, mode ? m_flag : (m_primed && !m_smp));
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        hold(3);
        chk("R1 irq in reset", irq, 1'b0);
        chk("R1 flag in reset", flag, 1'b0);
        rst_n = 1'b1;
        model_on = 1'b1;
        hold(1);
        chk("R1 irq after reset", irq, 1'b0);

        // R9: pin low through reset, edge mode, strobes running
        stb = 1'b1;
        hold(8);
        chk("R9 no flag from low pin at reset", flag, 1'b0);
        chk("R9 no request", irq, 1'b0);
        mode = 1'b0;
        hold(1);
        chk("R3 level low requests", irq, 1'b1);

        // R2: no strobe, no change
        stb = 1'b0; pin = 1'b1;
        hold(6);
        chk("R2 unchanged without strobe", irq, 1'b1);
        stb = 1'b1;
        hold(4);
        chk("R3 request drops on high sample", irq, 1'b0);
        chk("R3 no flag in level mode", flag, 1'b0);

        // R2 latency: change before edge k, visible after edge k+2
        pin = 1'b0;
        hold(2);
        chk("R2 not yet after two edges", irq, 1'b0);
        hold(1);
        chk("R2 visible after third edge", irq, 1'b1);

        // R4 / R5 / R11 in edge mode
        pin = 1'b1; mode = 1'b1;
        hold(5);
        chk("R4 no flag while high", flag, 1'b0);
        pin = 1'b0;
        hold(5);
        chk("R4 falling edge sets flag", flag, 1'b1);
        chk("R11 request equals flag", irq, 1'b1);
        pin = 1'b1;
        hold(5);
        chk("R5 flag held after pin returns high", flag, 1'b1);

        // R6 acknowledge
        ack = 1'b1; hold(1); ack = 1'b0;
        chk("R6 acknowledge clears", flag, 1'b0);
        chk("R11 request cleared", irq, 1'b0);

        // R7 software clear
        pin = 1'b0; hold(5);
        chk("R4 second edge sets", flag, 1'b1);
        clr = 1'b1; hold(1); clr = 1'b0;
        chk("R7 software clear", flag, 1'b0);

        // R8 set beats clear on the same edge (set lands on edge k+2)
        pin = 1'b1; hold(5);
        pin = 1'b0; hold(2);
        clr = 1'b1; hold(1); clr = 1'b0;
        chk("R8 set wins over software clear", flag, 1'b1);
        ack = 1'b1; hold(1); ack = 1'b0;
        chk("R6 cleared again", flag, 1'b0);
        pin = 1'b1; hold(5);
        pin = 1'b0; hold(2);
        ack = 1'b1; hold(1); ack = 1'b0;
        chk("R8 set wins over acknowledge", flag, 1'b1);
        clr = 1'b1; hold(1); clr = 1'b0;
        pin = 1'b1; hold(5);

        // R10 short pulse between strobes, both modes
        for (int m = 1; m >= 0; m--) begin
            mode = m[0];
            stb = 1'b1; hold(1);
            stb = 1'b0; pin = 1'b0; hold(1);
            pin = 1'b1; hold(2);
            stb = 1'b1; hold(1);
            stb = 1'b0; hold(3);
            chk("R10 short pulse: no flag", flag, 1'b0);
            chk("R10 short pulse: no request", irq, 1'b0);
        end

        // Mixed stimulus checked against the model on every clock
        mode = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) pin = ~pin;
            stb = ($urandom_range(0, 2) == 0);
            ack = ($urandom_range(0, 15) == 0);
            clr = ($urandom_range(0, 19) == 0);
            if ($urandom_range(0, 499) == 0) mode = ~mode;
            hold(1);
        end
        ack = 1'b0; clr = 1'b0; stb = 1'b0;
        hold(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule